// File: doc/BRIEF.md
# Semaphored SPI Host Register File

This block is the byte-wide register front end of a simple SPI host. A processor reaches it over a single-cycle bus with an address, a write enable, a read enable, an 8-bit write byte and a registered 8-bit read byte. The block holds the clock-mode and divider settings, holds the chip-select number, and exposes a fixed code that names the frequency of the serial base clock. Data-register traffic goes to a separate shift engine: a write starts that engine, and a read returns the byte it received.

Several processors can share the controller through a hardware semaphore in the status register. A read that finds the lock free returns it as free and claims it in the same access. Every later read sees it taken. Writing a one to that bit gives the lock back. The status register also shows whether the shift engine is still moving a byte. Chip select is held as an encoded number, and a decoder turns it into up to 255 active-low select lines. The reserved value 0xFF selects no device.

Top module: `spi_host_regs`

## Requirements
- R1: Offset 0x03 returns the fixed clock code CLK_ID in bits 3:0 and zero in bits 7:4 (code 0 = 62.5 MHz, 1 = 33.33 MHz, 2 = 125 MHz, 3 = 50 MHz, 4 = 100 MHz). Writes to it change nothing.
- R2: The control register sits at offset 0x04 and resets to 0x0F. Bits 3:0 drive clk_div, bit 4 drives cpha and bit 5 drives cpol. Bits 7:6 read as zero.
- R3: Status bit 0 at offset 0x08 is a semaphore. A read access that finds it clear returns 0 in that bit and sets it. Reads after that return 1 until it is released.
- R4: A read access is the first cycle of an rd_en pulse. Holding rd_en high for several cycles makes one access: the semaphore is claimed once and rdata keeps the value of that first cycle.
- R5: A write to offset 0x08 with bit 0 set clears the semaphore. A write with bit 0 clear leaves it unchanged.
- R6: Status bit 1 reads the eng_busy input. Status bits 7:2 read as zero.
- R7: A write to the data offset 0x0C while eng_busy is low raises eng_start for exactly the next cycle, with eng_tx equal to the written byte. A write while eng_busy is high is ignored: eng_start stays low and eng_tx is unchanged.
- R8: A read of offset 0x0C returns eng_rx.
- R9: The chip-select register at offset 0x10 resets to 0xFF and reads back as written. A value v below NUM_CS drives cs_n[v] low and all other lines high. Any other value, 0xFF included, drives every line high.
- R10: A read of an unmapped offset returns 0x00.
- R11: rdata is registered. It changes only in the cycle after a read access and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write enable, one access per cycle |
| rd_en | input | 1 | Read enable, one access per pulse |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| eng_busy | input | 1 | Shift engine is moving a byte |
| eng_rx | input | 8 | Byte received by the shift engine |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| eng_tx | output | 8 | Byte for the shift engine to send |
| clk_div | output | 4 | Divider code for the serial clock |
| cpha | output | 1 | Clock phase select |
| cpol | output | 1 | Clock polarity select |
| cs_n | output | NUM_CS | Active-low chip-select lines |

## Verification
On every cycle the assertions check the following: a claim or a release moves the semaphore, a write to the chip-select register pulls the indexed line low, eng_tx does not move while the engine is busy, unmapped reads return zero, and rdata holds between accesses. Some behaviour only the bench scenarios can show. These are the values each register returns in a claim, hold and release sequence, the one-claim-per-held-strobe behaviour, the busy write that is dropped, and the reset values against their encodings.

// File: rtl/spi_regs_pkg.sv
// Package: shared constants for the SPI host register file.
// Assumes byte-wide registers and offsets that fit in eight bits.
package spi_regs_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 4;
    localparam int MODE_W = 6;

    localparam logic [7:0] OFS_CLKID = 8'h03;
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_DATA  = 8'h0C;
    localparam logic [7:0] OFS_CSNUM = 8'h10;

    localparam logic [MODE_W-1:0] CTRL_RESET = 6'h0F;
    localparam logic [7:0]        CS_NONE    = 8'hFF;

    typedef enum logic [2:0] {
        REG_NONE, REG_CLKID, REG_CTRL, REG_STAT, REG_DATA, REG_CSNUM
    } reg_sel_t;
endpackage

// File: rtl/srh_semaphore.sv
// Module: ownership lock shared by several bus masters.
// A claim sets the lock and a release clears it. Release wins when both
// happen in one cycle. The caller samples held before the update.
module srh_semaphore (
    input  logic clk,
    input  logic rst_n,
    input  logic claim,
    input  logic release_req,
    output logic held
);
    logic held_q;

    // Lock state update: release has priority over claim.
    always_ff @(posedge clk) begin
        if (!rst_n)           held_q <= 1'b0;
        else if (release_req) held_q <= 1'b0;
        else if (claim)       held_q <= 1'b1;
    end

    assign held = held_q;

    assert_claim_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !release_req) |=> held);
    assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> !held);
endmodule

// File: rtl/srh_cs_decoder.sv
// Module: chip-select number register with a decoder to active-low lines.
// A value at or above NUM_CS, including 0xFF, deasserts all lines.
module srh_cs_decoder #(
    parameter int NUM_CS = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       sel,
    output logic [NUM_CS-1:0] cs_n
);
    logic [7:0] sel_q;

    // Holds the encoded select number.
    always_ff @(posedge clk) begin
        if (!rst_n)  sel_q <= spi_regs_pkg::CS_NONE;
        else if (wr) sel_q <= wdata;
    end

    // One comparator per line, each driving its own active-low select.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = (sel_q != 8'(i));
    end

    assign sel = sel_q;

    assert_at_most_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
endmodule

// File: rtl/spi_host_regs.sv
// Module: register front end of an SPI host.
// It decodes byte offsets and keeps the control and chip-select registers.
// It runs the status semaphore and passes data-register traffic to an
// external shift engine. A read access is the first cycle of an rd_en
// pulse. Writes act in every cycle in which wr_en is high.
module spi_host_regs
    import spi_regs_pkg::*;
#(
    parameter int         ADDR_W = 5,
    parameter int         NUM_CS = 255,
    parameter logic [3:0] CLK_ID = 4'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              eng_busy,
    input  logic [7:0]        eng_rx,
    output logic              eng_start,
    output logic [7:0]        eng_tx,
    output logic [DIV_W-1:0]  clk_div,
    output logic              cpha,
    output logic              cpol,
    output logic [NUM_CS-1:0] cs_n
);
    reg_sel_t          rsel;
    logic              rd_en_q, rd_strobe;
    logic              sem_held;
    logic [MODE_W-1:0] ctrl_q;
    logic [7:0]        cs_sel;
    logic [7:0]        rd_mux, rdata_q;
    logic              start_q;
    logic [7:0]        tx_q;
    logic              seen_q;

    // Maps the bus offset to a register select.
    always_comb begin
        rsel = REG_NONE;
        if      (addr == ADDR_W'(OFS_CLKID)) rsel = REG_CLKID;
        else if (addr == ADDR_W'(OFS_CTRL))  rsel = REG_CTRL;
        else if (addr == ADDR_W'(OFS_STAT))  rsel = REG_STAT;
        else if (addr == ADDR_W'(OFS_DATA))  rsel = REG_DATA;
        else if (addr == ADDR_W'(OFS_CSNUM)) rsel = REG_CSNUM;
    end

    // Remembers rd_en so that one pulse makes one access.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_en_q <= 1'b0;
        else        rd_en_q <= rd_en;
    end
    assign rd_strobe = rd_en && !rd_en_q;

    srh_semaphore u_sem (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim      (rd_strobe && rsel == REG_STAT),
        .release_req(wr_en && rsel == REG_STAT && wdata[0]),
        .held       (sem_held)
    );

    srh_cs_decoder #(.NUM_CS(NUM_CS)) u_cs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_en && rsel == REG_CSNUM),
        .wdata(wdata),
        .sel  (cs_sel),
        .cs_n (cs_n)
    );

    // Control register: divider code with phase and polarity bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ctrl_q <= CTRL_RESET;
        else if (wr_en && rsel == REG_CTRL) ctrl_q <= wdata[MODE_W-1:0];
    end
    assign clk_div = ctrl_q[DIV_W-1:0];
    assign cpha    = ctrl_q[4];
    assign cpol    = ctrl_q[5];

    // Starts the shift engine on a data write unless it is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            tx_q    <= '0;
        end else begin
            start_q <= wr_en && rsel == REG_DATA && !eng_busy;
            if (wr_en && rsel == REG_DATA && !eng_busy) tx_q <= wdata;
        end
    end
    assign eng_start = start_q;
    assign eng_tx    = tx_q;

    // Selects the byte that a read returns.
    always_comb begin
        unique case (rsel)
            REG_CLKID: rd_mux = {4'h0, CLK_ID};
            REG_CTRL:  rd_mux = {2'b00, ctrl_q};
            REG_STAT:  rd_mux = {6'b0, eng_busy, sem_held};
            REG_DATA:  rd_mux = eng_rx;
            REG_CSNUM: rd_mux = cs_sel;
            default:   rd_mux = 8'h00;
        endcase
    end

    // Captures read data once per access.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= 8'h00;
        else if (rd_strobe) rdata_q <= rd_mux;
    end
    assign rdata = rdata_q;

    // Marks the cycles in which $past reaches back past reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rsel == REG_NONE) |=> rdata == 8'h00);
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !rd_strobe) |=> $stable(rdata));
    assert_busy_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && eng_busy) |=> (!eng_start && $stable(eng_tx)));
    assert_cs_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rsel == REG_CSNUM && int'(wdata) < NUM_CS) |=> !cs_n[$past(wdata)]);
endmodule

// File: tb/sim_spi_host_regs.sv
// Bench: a scoreboard for the register file. The driver tasks queue the
// expected read bytes, and a monitor compares them as rdata updates.
module sim_spi_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS     = 255;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, eng_busy = 1'b0;
    logic [7:0] wdata = '0, eng_rx = '0;
    logic [7:0] rdata, eng_tx;
    logic eng_start, cpha, cpol;
    logic [3:0] clk_div;
    logic [NUM_CS-1:0] cs_n;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       chk_q = 1'b0;

    spi_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .eng_busy(eng_busy), .eng_rx(eng_rx),
        .eng_start(eng_start), .eng_tx(eng_tx), .clk_div(clk_div),
        .cpha(cpha), .cpol(cpol), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every rd_en cycle loads a scoreboard slot for the next low phase.
    always @(posedge clk) chk_q <= rd_en;
    always @(negedge clk) begin
        if (chk_q) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: actual %0h expected nothing", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(t, {24'h0, rdata}, {24'h0, e});
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        addr = a[4:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // A read held for cycles cycles; each cycle expects exp.
    task automatic do_read(input logic [7:0] a, input logic [7:0] exp,
                           input string req, input int cycles = 1);
        addr = a[4:0]; rd_en = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            exp_q.push_back(exp); tag_q.push_back(req);
            @(negedge clk);
        end
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R9 reset lines", {31'h0, &cs_n}, 32'h1);
        check("R2 reset div", {28'h0, clk_div}, 32'hF);
        check("R2 reset mode", {30'h0, cpol, cpha}, 32'h0);
        check("R7 reset start", {31'h0, eng_start}, 32'h0);
        check("R11 reset rdata", {24'h0, rdata}, 32'h0);
        do_read(8'h04, 8'h0F, "R2 ctrl reset");
        do_read(8'h10, 8'hFF, "R9 cs reset");
        do_read(8'h03, 8'h04, "R1 clock code");
        do_read(8'h00, 8'h00, "R10 offset 0");
        do_read(8'h1F, 8'h00, "R10 offset 1F");
        do_write(8'h03, 8'hAA);
        do_read(8'h03, 8'h04, "R1 write ignored");
        // R2 control fields
        do_write(8'h04, 8'hFF);
        check("R2 div all", {28'h0, clk_div}, 32'hF);
        check("R2 mode all", {30'h0, cpol, cpha}, 32'h3);
        do_read(8'h04, 8'h3F, "R2 upper bits zero");
        do_write(8'h04, 8'h12);
        check("R2 div 2", {28'h0, clk_div}, 32'h2);
        check("R2 cpha only", {30'h0, cpol, cpha}, 32'h1);
        // R3 and R5 semaphore
        do_read(8'h08, 8'h00, "R3 first claim");
        do_read(8'h08, 8'h01, "R3 taken");
        do_write(8'h08, 8'h00);
        do_read(8'h08, 8'h01, "R5 zero write keeps lock");
        do_write(8'h08, 8'h01);
        do_read(8'h08, 8'h00, "R5 released then claimed");
        do_read(8'h08, 8'h01, "R3 taken again");
        do_write(8'h08, 8'h01);
        // R4 held strobe claims once and holds rdata
        do_read(8'h08, 8'h00, "R4 held read", 3);
        do_read(8'h08, 8'h01, "R4 after held read");
        do_write(8'h08, 8'h01);
        // R6 busy bit
        eng_busy = 1'b1;
        do_read(8'h08, 8'h02, "R6 busy free");
        do_read(8'h08, 8'h03, "R6 busy held");
        eng_busy = 1'b0;
        do_read(8'h08, 8'h01, "R6 idle held");
        do_write(8'h08, 8'h01);
        // R7 data writes
        do_write(8'h0C, 8'hA5);
        check("R7 start pulse", {31'h0, eng_start}, 32'h1);
        check("R7 tx byte", {24'h0, eng_tx}, 32'hA5);
        @(negedge clk);
        check("R7 single pulse", {31'h0, eng_start}, 32'h0);
        eng_busy = 1'b1;
        do_write(8'h0C, 8'h3C);
        check("R7 busy no start", {31'h0, eng_start}, 32'h0);
        check("R7 busy tx kept", {24'h0, eng_tx}, 32'hA5);
        eng_busy = 1'b0;
        // R8 data read
        eng_rx = 8'h5A;
        do_read(8'h0C, 8'h5A, "R8 rx byte");
        // R9 chip select
        do_write(8'h10, 8'h00);
        check("R9 line 0 low", {31'h0, cs_n[0]}, 32'h0);
        check("R9 one low", $countones(cs_n), NUM_CS - 1);
        do_write(8'h10, 8'd254);
        check("R9 line 254 low", {31'h0, cs_n[254]}, 32'h0);
        check("R9 one low top", $countones(cs_n), NUM_CS - 1);
        do_write(8'h10, 8'h80);
        check("R9 line 128 low", {31'h0, cs_n[128]}, 32'h0);
        do_read(8'h10, 8'h80, "R9 readback");
        do_write(8'h10, 8'hFF);
        check("R9 none", {31'h0, &cs_n}, 32'h1);
        // R11 rdata holds while idle
        repeat (3) @(negedge clk);
        check("R11 rdata held", {24'h0, rdata}, 32'h80);
        if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule